// File: doc/BRIEF.md
# CRC-6 Word Protection Checker

This block protects each parallel video word that crosses a serial link with a 6-bit cyclic check and one alignment parity bit. The transmit half takes an already scrambled payload word and returns a frame holding the payload, the 6-bit check field and a parity bit. The receive half takes a frame from the link, recomputes the check over the payload, compares it with the received field and checks parity. A bad word raises a one-cycle error strobe and advances a saturating error counter that can be cleared synchronously.

A width-select input picks a 16-bit or a 24-bit payload. A mode input picks full protection (check field and parity), parity-only protection, or bypass. The receiver leans on the parity bit to find word boundaries, so parity is produced in both protected modes. Scrambling, byte coding and serialization are outside this block.

Frame layout, bit 0 first: check field in bits [5:0], payload in bits [6 +: PW], parity at bit 6+PW, and zeros above it. PW is 16 when `wide_i` is 0 and 24 when it is 1.

Top module: `crc6_link_guard`

## Requirements
- R1: In mode 2'b10, one cycle after `tx_valid_i` the block raises `tx_valid_o` for one cycle. In that cycle `tx_frame_o[5:0]` holds the CRC of the active payload under x^6+x+1, with the register starting at zero, bits taken MSB first and no final inversion, and the payload sits in bits [6 +: PW].
- R2: In modes 2'b01 and 2'b10 the transmit bit 6+PW makes the XOR of payload, check field and that bit equal 0 (even parity). All frame bits above 6+PW are 0.
- R3: With `wide_i`=0 the payload is `tx_payload_i[15:0]`, and bits [23:16] have no effect on the frame. With `wide_i`=1 all 24 bits are used.
- R4: In mode 2'b01 the transmit check field is 0. On receive only parity errors count, and a check-field mismatch raises no flag.
- R5: Modes 2'b00 and 2'b11 are bypass. The transmit check field and parity bit are 0, and no received frame raises any flag or changes the counter.
- R6: In mode 2'b10, a received frame whose check field differs from the recomputed CRC raises `crc_err_o` and `err_o` for one cycle, one cycle after `rx_valid_i`.
- R7: In modes 2'b01 and 2'b10, a received frame whose bits [6+PW:0] have odd XOR raises `par_err_o` and `err_o` for one cycle, one cycle after `rx_valid_i`.
- R8: `err_cnt_o` (8 bits) rises by exactly one for each word that raises `err_o`, even when both error kinds hit. It updates in the same cycle as `err_o` and holds at 255.
- R9: `cnt_clr_i`, sampled with a received word, zeroes the counter at that edge. If that same word is bad, the counter reads 1 rather than 0.
- R10: While `rx_valid_i` is low, no error flag rises and the counter only changes by a clear.
- R11: After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | 00/11 bypass, 01 parity only, 10 CRC plus parity |
| wide_i | input | 1 | 0: 16-bit payload, 1: 24-bit payload |
| tx_valid_i | input | 1 | Transmit word present |
| tx_payload_i | input | 24 | Scrambled payload word |
| tx_valid_o | output | 1 | Frame valid on `tx_frame_o` |
| tx_frame_o | output | 31 | Protected frame |
| rx_valid_i | input | 1 | Received frame present |
| rx_frame_i | input | 31 | Received frame |
| cnt_clr_i | input | 1 | Synchronous counter clear |
| err_o | output | 1 | One-cycle strobe per bad word |
| crc_err_o | output | 1 | Check-field mismatch seen |
| par_err_o | output | 1 | Parity error seen |
| err_cnt_o | output | 8 | Saturating count of bad words |

## Verification
The counter clear and a newly detected bad word can land on the same clock edge. The counter then has to restart at one, not zero, and must not keep its old value. The bench pulses the clear together with corrupted frames, with clean frames, and at random points in a long random stream. A reference counter in the bench applies clear-then-count and is compared with the port in the cycle the strobe appears. The saturation edge is also driven with the clear released, so a bad word at 255 must leave the counter at 255.

// File: rtl/lg_pkg.sv
package lg_pkg;
  localparam int LG_CRC_W  = 6;
  localparam int LG_MAX_PW = 32;
  localparam logic [LG_CRC_W-1:0] LG_POLY_TAPS = 6'b000011;

  typedef enum logic [1:0] {
    MODE_BYPASS  = 2'b00,
    MODE_PARITY  = 2'b01,
    MODE_CRC     = 2'b10,
    MODE_BYPASS2 = 2'b11
  } lg_mode_e;

  typedef struct packed {
    logic crc_bad;
    logic par_bad;
  } lg_verdict_t;

  // Serial CRC update, MSB first, zero start, no final inversion.
  function automatic logic [LG_CRC_W-1:0] lg_crc6(input logic [LG_MAX_PW-1:0] data,
                                                  input int len);
    logic [LG_CRC_W-1:0] r;
    logic fb;
    r = '0;
    for (int i = LG_MAX_PW - 1; i >= 0; i--) begin
      if (i < len) begin
        fb = data[i] ^ r[LG_CRC_W-1];
        r  = {r[LG_CRC_W-2:0], 1'b0} ^ (fb ? LG_POLY_TAPS : '0);
      end
    end
    return r;
  endfunction

  // Bit that brings payload plus check field to even weight.
  function automatic logic lg_even_bit(input logic [LG_MAX_PW-1:0] data,
                                       input logic [LG_CRC_W-1:0] chk);
    return (^data) ^ (^chk);
  endfunction

  function automatic logic lg_protected(input lg_mode_e m);
    return (m == MODE_PARITY) || (m == MODE_CRC);
  endfunction
endpackage

// File: rtl/lg_payload_sel.sv
module lg_payload_sel
  import lg_pkg::*;
#(
  parameter int NARROW_W = 16,
  parameter int WIDE_W   = 24
) (
  input  logic                 wide_i,
  input  logic [WIDE_W-1:0]    payload_i,
  output logic [LG_MAX_PW-1:0] active_o,
  output int                   len_o
);
  always_comb begin
    active_o = '0;
    if (wide_i) begin
      active_o[WIDE_W-1:0] = payload_i;
      len_o = WIDE_W;
    end else begin
      active_o[NARROW_W-1:0] = payload_i[NARROW_W-1:0];
      len_o = NARROW_W;
    end
  end
endmodule

// File: rtl/lg_tx_encoder.sv
module lg_tx_encoder
  import lg_pkg::*;
#(
  parameter int NARROW_W = 16,
  parameter int WIDE_W   = 24,
  localparam int FRAME_W = WIDE_W + LG_CRC_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  lg_mode_e           mode,
  input  logic               wide_i,
  input  logic               valid_i,
  input  logic [WIDE_W-1:0]  payload_i,
  output logic               valid_o,
  output logic [FRAME_W-1:0] frame_o
);
  logic [LG_MAX_PW-1:0] active;
  int                   len;
  logic [LG_CRC_W-1:0]  chk;
  logic                 par;
  logic [FRAME_W-1:0]   frame_d;

  lg_payload_sel #(.NARROW_W(NARROW_W), .WIDE_W(WIDE_W)) u_sel (
    .wide_i   (wide_i),
    .payload_i(payload_i),
    .active_o (active),
    .len_o    (len)
  );

  always_comb begin
    chk = (mode == MODE_CRC) ? lg_crc6(active, len) : '0;
    par = lg_protected(mode) ? lg_even_bit(active, chk) : 1'b0;
    frame_d = '0;
    frame_d[LG_CRC_W-1:0] = chk;
    if (wide_i) begin
      frame_d[LG_CRC_W +: WIDE_W]  = active[WIDE_W-1:0];
      frame_d[LG_CRC_W + WIDE_W]   = par;
    end else begin
      frame_d[LG_CRC_W +: NARROW_W] = active[NARROW_W-1:0];
      frame_d[LG_CRC_W + NARROW_W]  = par;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      frame_o <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) frame_o <= frame_d;
    end
  end
endmodule

// File: rtl/lg_rx_checker.sv
module lg_rx_checker
  import lg_pkg::*;
#(
  parameter int NARROW_W = 16,
  parameter int WIDE_W   = 24,
  localparam int FRAME_W = WIDE_W + LG_CRC_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  lg_mode_e           mode,
  input  logic               wide_i,
  input  logic               valid_i,
  input  logic [FRAME_W-1:0] frame_i,
  output logic               word_bad_o,
  output logic               crc_err_o,
  output logic               par_err_o,
  output logic               err_o
);
  logic [WIDE_W-1:0]    field_payload;
  logic                 field_par;
  logic [LG_CRC_W-1:0]  field_chk;
  logic [LG_MAX_PW-1:0] active;
  int                   len;
  lg_verdict_t          raw;
  lg_verdict_t          gated;

  always_comb begin
    field_chk     = frame_i[LG_CRC_W-1:0];
    field_payload = '0;
    if (wide_i) begin
      field_payload = frame_i[LG_CRC_W +: WIDE_W];
      field_par     = frame_i[LG_CRC_W + WIDE_W];
    end else begin
      field_payload[NARROW_W-1:0] = frame_i[LG_CRC_W +: NARROW_W];
      field_par                   = frame_i[LG_CRC_W + NARROW_W];
    end
  end

  lg_payload_sel #(.NARROW_W(NARROW_W), .WIDE_W(WIDE_W)) u_sel (
    .wide_i   (wide_i),
    .payload_i(field_payload),
    .active_o (active),
    .len_o    (len)
  );

  always_comb begin
    raw.crc_bad   = lg_crc6(active, len) != field_chk;
    raw.par_bad   = lg_even_bit(active, field_chk) != field_par;
    gated.crc_bad = valid_i && (mode == MODE_CRC) && raw.crc_bad;
    gated.par_bad = valid_i && lg_protected(mode) && raw.par_bad;
  end

  assign word_bad_o = gated.crc_bad | gated.par_bad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_err_o <= 1'b0;
      par_err_o <= 1'b0;
      err_o     <= 1'b0;
    end else begin
      crc_err_o <= gated.crc_bad;
      par_err_o <= gated.par_bad;
      err_o     <= word_bad_o;
    end
  end
endmodule

// File: rtl/lg_err_counter.sv
module lg_err_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             bump_i,
  output logic [CNT_W-1:0] count_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] base;
  logic [CNT_W-1:0] next;

  always_comb begin
    base = clr_i ? '0 : count_o;
    next = base;
    if (bump_i && base != CNT_MAX) next = base + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count_o <= '0;
    else        count_o <= next;
  end
endmodule

// File: rtl/crc6_link_guard.sv
module crc6_link_guard
  import lg_pkg::*;
#(
  parameter int NARROW_W = 16,
  parameter int WIDE_W   = 24,
  parameter int CNT_W    = 8,
  localparam int FRAME_W = WIDE_W + LG_CRC_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         mode_i,
  input  logic               wide_i,
  input  logic               tx_valid_i,
  input  logic [WIDE_W-1:0]  tx_payload_i,
  output logic               tx_valid_o,
  output logic [FRAME_W-1:0] tx_frame_o,
  input  logic               rx_valid_i,
  input  logic [FRAME_W-1:0] rx_frame_i,
  input  logic               cnt_clr_i,
  output logic               err_o,
  output logic               crc_err_o,
  output logic               par_err_o,
  output logic [CNT_W-1:0]   err_cnt_o
);
  lg_mode_e mode;
  logic     rx_word_bad;

  assign mode = lg_mode_e'(mode_i);

  lg_tx_encoder #(.NARROW_W(NARROW_W), .WIDE_W(WIDE_W)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (mode),
    .wide_i   (wide_i),
    .valid_i  (tx_valid_i),
    .payload_i(tx_payload_i),
    .valid_o  (tx_valid_o),
    .frame_o  (tx_frame_o)
  );

  lg_rx_checker #(.NARROW_W(NARROW_W), .WIDE_W(WIDE_W)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode),
    .wide_i    (wide_i),
    .valid_i   (rx_valid_i),
    .frame_i   (rx_frame_i),
    .word_bad_o(rx_word_bad),
    .crc_err_o (crc_err_o),
    .par_err_o (par_err_o),
    .err_o     (err_o)
  );

  lg_err_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (cnt_clr_i),
    .bump_i (rx_word_bad),
    .count_o(err_cnt_o)
  );
endmodule

// File: rtl/lg_guard_checker.sv
module lg_guard_checker #(
  parameter int CNT_W   = 8,
  parameter int FRAME_W = 31
) (
  input logic               clk,
  input logic               rst_n,
  input logic [1:0]         mode_i,
  input logic               tx_valid_i,
  input logic               tx_valid_o,
  input logic [FRAME_W-1:0] tx_frame_o,
  input logic               rx_valid_i,
  input logic               rx_bad,
  input logic               cnt_clr_i,
  input logic               err_o,
  input logic               crc_err_o,
  input logic [CNT_W-1:0]   err_cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  function automatic logic [CNT_W-1:0] sat_step(input logic [CNT_W-1:0] c, input logic b);
    return (b && c != CNT_MAX) ? c + 1'b1 : c;
  endfunction

  assert_tx_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid_i |=> tx_valid_o);
  assert_tx_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_valid_i |=> !tx_valid_o);
  assert_tx_even_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid_i && (mode_i == 2'b01 || mode_i == 2'b10)) |=> (^tx_frame_o) == 1'b0);
  assert_bypass_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'b00 || mode_i == 2'b11) |=> !err_o);
  assert_crc_only_in_crc_mode_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i != 2'b10) |=> !crc_err_o);
  assert_strobe_follows_verdict_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_bad |=> err_o);
  assert_cnt_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_clr_i |=> err_cnt_o == sat_step($past(err_cnt_o), err_o));
  assert_clear_collide_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr_i |=> err_cnt_o == {{(CNT_W-1){1'b0}}, err_o});
  assert_no_flag_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid_i |=> !err_o);
endmodule

bind crc6_link_guard lg_guard_checker #(.CNT_W(CNT_W), .FRAME_W(FRAME_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mode_i    (mode_i),
  .tx_valid_i(tx_valid_i),
  .tx_valid_o(tx_valid_o),
  .tx_frame_o(tx_frame_o),
  .rx_valid_i(rx_valid_i),
  .rx_bad    (rx_word_bad),
  .cnt_clr_i (cnt_clr_i),
  .err_o     (err_o),
  .crc_err_o (crc_err_o),
  .err_cnt_o (err_cnt_o)
);

// File: tb/sim_crc6_link_guard.sv
`timescale 1ns/1ps
module sim_crc6_link_guard;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode_i = 2'b10;
  logic        wide_i = 1'b0;
  logic        tx_valid_i = 1'b0;
  logic [23:0] tx_payload_i = '0;
  logic        tx_valid_o;
  logic [30:0] tx_frame_o;
  logic        rx_valid_i = 1'b0;
  logic [30:0] rx_frame_i = '0;
  logic        cnt_clr_i = 1'b0;
  logic        err_o, crc_err_o, par_err_o;
  logic [7:0]  err_cnt_o;

  int n_chk = 0;
  int n_bad = 0;
  int model_cnt = 0;
  bit done = 0;

  always #10 clk = ~clk;

  crc6_link_guard u0 (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .wide_i(wide_i),
    .tx_valid_i(tx_valid_i), .tx_payload_i(tx_payload_i),
    .tx_valid_o(tx_valid_o), .tx_frame_o(tx_frame_o),
    .rx_valid_i(rx_valid_i), .rx_frame_i(rx_frame_i), .cnt_clr_i(cnt_clr_i),
    .err_o(err_o), .crc_err_o(crc_err_o), .par_err_o(par_err_o), .err_cnt_o(err_cnt_o)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Remainder of data*x^6 divided by x^6+x+1, by long division.
  function automatic logic [5:0] ref_crc(input logic [23:0] d, input int len);
    logic [38:0] m;
    m = {15'b0, d} << 6;
    for (int i = len + 5; i >= 6; i--)
      if (m[i]) m = m ^ (39'b1000011 << (i - 6));
    return m[5:0];
  endfunction

  function automatic logic [30:0] ref_frame(input logic [23:0] p, input bit w, input logic [1:0] m);
    int pw;
    logic [23:0] a;
    logic [5:0] c;
    logic par;
    pw = w ? 24 : 16;
    a = w ? p : {8'b0, p[15:0]};
    c = (m == 2'b10) ? ref_crc(a, pw) : 6'b0;
    par = (m == 2'b01 || m == 2'b10) ? ((^a) ^ (^c)) : 1'b0;
    return (31'(a) << 6) | 31'(c) | (31'(par) << (6 + pw));
  endfunction

  task automatic do_tx(input logic [23:0] p, input bit w, input logic [1:0] m, input string req);
    logic [30:0] e;
    @(negedge clk);
    mode_i = m; wide_i = w; tx_payload_i = p; tx_valid_i = 1'b1;
    @(negedge clk);
    tx_valid_i = 1'b0;
    e = ref_frame(p, w, m);
    check(tx_valid_o == 1'b1, {req, " tx_valid_o"}, 32'(tx_valid_o), 32'd1);
    check(tx_frame_o == e, {req, " tx_frame_o"}, 32'(tx_frame_o), 32'(e));
  endtask

  // Drives one received frame and compares flags and counter one cycle later.
  task automatic do_rx(input logic [30:0] f, input bit w, input logic [1:0] m,
                       input bit v, input bit clr, input string req);
    int pw;
    logic [23:0] a;
    bit cb, pb, eb;
    pw = w ? 24 : 16;
    a = w ? f[29:6] : {8'b0, f[21:6]};
    cb = v && (m == 2'b10) && (ref_crc(a, pw) != f[5:0]);
    pb = v && (m == 2'b01 || m == 2'b10) && ((^(f & ((31'd1 << (7 + pw)) - 31'd1))) == 1'b1);
    eb = cb || pb;
    if (clr) model_cnt = 0;
    if (eb && model_cnt != 255) model_cnt++;
    @(negedge clk);
    mode_i = m; wide_i = w; rx_frame_i = f; rx_valid_i = v; cnt_clr_i = clr;
    @(negedge clk);
    rx_valid_i = 1'b0; cnt_clr_i = 1'b0;
    check(crc_err_o == cb, {req, " crc_err_o"}, 32'(crc_err_o), 32'(cb));
    check(par_err_o == pb, {req, " par_err_o"}, 32'(par_err_o), 32'(pb));
    check(err_o == eb, {req, " err_o"}, 32'(err_o), 32'(eb));
    check(err_cnt_o == 8'(model_cnt), {req, " err_cnt_o"}, 32'(err_cnt_o), 32'(model_cnt));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [30:0] g;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R11 reset state
    check(tx_valid_o == 0 && tx_frame_o == 0, "R11 tx outputs", 32'(tx_frame_o), 32'd0);
    check(err_o == 0 && crc_err_o == 0 && par_err_o == 0, "R11 flags", 32'({err_o, crc_err_o, par_err_o}), 32'd0);
    check(err_cnt_o == 0, "R11 counter", 32'(err_cnt_o), 32'd0);
    rst_n = 1'b1;

    // R1 R2 directed CRC frames
    do_tx(24'h000001, 1'b0, 2'b10, "R1 single bit");
    do_tx(24'h00FFFF, 1'b0, 2'b10, "R1 narrow ones");
    do_tx(24'hFFFFFF, 1'b1, 2'b10, "R2 wide ones");
    do_tx(24'h800000, 1'b1, 2'b10, "R1 wide msb");
    // R3 upper bits ignored when narrow
    do_tx(24'hA51234, 1'b0, 2'b10, "R3 narrow upper set");
    check(tx_frame_o == ref_frame(24'h001234, 1'b0, 2'b10), "R3 upper bits no effect",
          32'(tx_frame_o), 32'(ref_frame(24'h001234, 1'b0, 2'b10)));
    // R4 parity-only transmit, R5 bypass transmit
    do_tx(24'h00BEEF, 1'b0, 2'b01, "R4 parity tx");
    do_tx(24'hC0FFEE, 1'b1, 2'b00, "R5 bypass tx");
    do_tx(24'hC0FFEE, 1'b1, 2'b11, "R5 bypass alt tx");

    // R6 crc mismatch with parity kept good (two flips inside check field)
    g = ref_frame(24'h004321, 1'b0, 2'b10);
    do_rx(g, 1'b0, 2'b10, 1'b1, 1'b0, "R6 clean");
    do_rx(g ^ 31'h3, 1'b0, 2'b10, 1'b1, 1'b0, "R6 crc only");
    // R7 parity bit flip alone
    do_rx(g ^ (31'd1 << 22), 1'b0, 2'b10, 1'b1, 1'b0, "R7 parity flip");
    // R8 both kinds in one word counts once
    do_rx(g ^ 31'h40, 1'b0, 2'b10, 1'b1, 1'b0, "R8 both errors");
    // R4 parity-only receive ignores crc mismatch
    g = ref_frame(24'h123456, 1'b1, 2'b01);
    do_rx(g ^ 31'h3, 1'b1, 2'b01, 1'b1, 1'b0, "R4 crc ignored");
    do_rx(g ^ 31'h1, 1'b1, 2'b01, 1'b1, 1'b0, "R4 parity counted");
    // R5 bypass receive
    do_rx(31'h5, 1'b1, 2'b00, 1'b1, 1'b0, "R5 bypass rx");
    do_rx(31'h5, 1'b1, 2'b11, 1'b1, 1'b0, "R5 bypass alt rx");
    // R10 idle with garbage
    do_rx(31'h1, 1'b0, 2'b10, 1'b0, 1'b0, "R10 idle");
    // R9 clear colliding with bad and good words
    do_rx(31'h1, 1'b0, 2'b10, 1'b1, 1'b1, "R9 clear with error");
    do_rx(ref_frame(24'h0, 1'b0, 2'b10), 1'b0, 2'b10, 1'b1, 1'b1, "R9 clear clean");
    do_rx(31'h1, 1'b0, 2'b10, 0, 1'b1, "R9 clear idle");

    // R8 saturation
    for (int k = 0; k < 258; k++) do_rx(31'h1, 1'b1, 2'b10, 1'b1, 1'b0, "R8 saturate");
    check(err_cnt_o == 8'd255, "R8 held at max", 32'(err_cnt_o), 32'd255);
    do_rx(31'h1, 1'b1, 2'b10, 1'b1, 1'b1, "R9 clear at max");

    // random mix
    for (int k = 0; k < 400; k++) begin
      logic [23:0] p;
      bit w;
      logic [1:0] m;
      int nflip;
      p = 24'($urandom);
      w = 1'($urandom);
      m = 2'($urandom);
      do_tx(p, w, m, "R1 R2 random tx");
      g = ref_frame(p, w, m);
      nflip = $urandom_range(0, 2);
      for (int j = 0; j < nflip; j++) g[$urandom_range(0, 30)] ^= 1'b1;
      do_rx(g, w, m, ($urandom_range(0, 7) != 0), ($urandom_range(0, 9) == 0), "R6 R7 R9 random rx");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule